// File: doc/BRIEF.md
# Single-Word Byte-Stream Command Server

This block serves one 32-bit stored word over a byte link. Bytes arrive through a valid/ready input handshake and are parsed as one of two 4-byte ASCII commands. A read command streams the stored word back as four bytes through a valid/ready output handshake. A write command must be followed directly by four payload bytes, and those bytes replace the stored word.

The block handles one command per connection. The surrounding logic pulses `conn_start` each time a new connection opens. This returns the parser to the start of a command, but it does not clear the stored word, so a value written in one connection can be read in a later one. Connection management and all network framing are handled outside the block.

Top module: `word_cmd_server`

## Requirements
- R1: After reset, in_ready is high and out_valid, done and err are low. The stored word is 0x00000000, so a read issued at once returns four zero bytes.
- R2: The read command is the bytes 0x47, 0x45, 0x54 ("GET"). It is dispatched when the third byte is accepted. The block then sends the four bytes of the stored word, most significant first.
- R3: While a response byte is offered, out_valid stays high and out_data stays unchanged until out_ready is sampled high. in_ready is low for as long as a response is pending.
- R4: The write command is the bytes 0x50, 0x4F, 0x53, 0x54 ("POST"), followed directly by four payload bytes, most significant first. For example, payload 0xBA 0xAD 0xF0 0x0D stores 0xBAADF00D.
- R5: The stored word changes only at the clock edge that accepts the fourth payload byte. A connection restart before that point keeps the old value.
- R6: A byte that does not match the expected keyword byte sets err. err stays high until the next conn_start. While err is high, further bytes are accepted and ignored: nothing is sent and the stored word does not change.
- R7: conn_start clears err and returns the parser to the first keyword byte. The stored word is kept.
- R8: After a command completes, further bytes in the same connection are accepted and ignored. They produce no output, no change to the word, and no err.
- R9: done is a one-cycle pulse. It is raised in the cycle after the last response byte is accepted, or after the fourth payload byte is accepted. done is never high together with err.
- R10: In a cycle where conn_start is high, in_ready is low, so no input byte is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_start | input | 1 | One-cycle pulse that marks the start of a new connection |
| in_valid | input | 1 | An input byte is offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | The block takes the offered byte |
| out_valid | output | 1 | A response byte is offered |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | The sink takes the response byte |
| done | output | 1 | Pulse when a command completes |
| err | output | 1 | A malformed command was seen in this connection |

## Verification
The hardest case to reach is a connection abandoned partway through a write payload. Only a later read can show that the old word survived, and that read must happen in a fresh connection. The stimulus sends the write keyword and two payload bytes, pulses conn_start with a byte still offered on the input, and then issues a read. Response back-pressure comes from a periodic out_ready pattern, so every read contains stalled bytes and the hold rule is exercised.

// File: rtl/wsrv_pkg.sv
package wsrv_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_PAY,
    ST_SEND,
    ST_FIN,
    ST_ERR
  } wsrv_state_t;

  localparam logic [7:0] CH_G = 8'h47;
  localparam logic [7:0] CH_E = 8'h45;
  localparam logic [7:0] CH_T = 8'h54;
  localparam logic [7:0] CH_P = 8'h50;
  localparam logic [7:0] CH_O = 8'h4F;
  localparam logic [7:0] CH_S = 8'h53;

  // Expected keyword byte at a given position.
  function automatic logic [7:0] kw_char(input logic is_wr, input logic [1:0] pos);
    if (is_wr) begin
      case (pos)
        2'd0:    kw_char = CH_P;
        2'd1:    kw_char = CH_O;
        2'd2:    kw_char = CH_S;
        default: kw_char = CH_T;
      endcase
    end else begin
      case (pos)
        2'd0:    kw_char = CH_G;
        2'd1:    kw_char = CH_E;
        default: kw_char = CH_T;
      endcase
    end
  endfunction

  // Position of the final keyword byte.
  function automatic logic [1:0] kw_last(input logic is_wr);
    kw_last = is_wr ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/wsrv_kw_match.sv
module wsrv_kw_match
  import wsrv_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic [1:0] pos_i,
  input  logic       kind_i,
  output logic       hit_o,
  output logic       last_o,
  output logic       kind_o
);

  always_comb begin
    if (pos_i == 2'd0) begin
      kind_o = (byte_i == CH_P);
      hit_o  = (byte_i == CH_P) || (byte_i == CH_G);
      last_o = 1'b0;
    end else begin
      kind_o = kind_i;
      hit_o  = (byte_i == kw_char(kind_i, pos_i));
      last_o = (pos_i == kw_last(kind_i));
    end
  end

endmodule

// File: rtl/wsrv_word_store.sv
module wsrv_word_store
  import wsrv_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [BYTE_W-1:0]            byte_i,
  output logic [WORD_BYTES*BYTE_W-1:0] word_o,
  output logic                         commit_o
);

  localparam int WORD_W = WORD_BYTES * BYTE_W;
  localparam int CNT_W  = $clog2(WORD_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] word_q;

  assign commit_o = push_i && !clr_i && (cnt_q == LAST);
  assign word_o   = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      word_q   <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      shadow_q <= {shadow_q[WORD_W-BYTE_W-1:0], byte_i};
      if (cnt_q == LAST) begin
        word_q <= {shadow_q[WORD_W-BYTE_W-1:0], byte_i};
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  word_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q != $past(word_q)) |-> $past(commit_o));

endmodule

// File: rtl/wsrv_tx_stream.sv
module wsrv_tx_stream
  import wsrv_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         abort_i,
  input  logic [WORD_BYTES*BYTE_W-1:0] word_i,
  input  logic                         out_ready_i,
  output logic                         out_valid_o,
  output logic [BYTE_W-1:0]            out_data_o,
  output logic                         finish_o
);

  localparam int CNT_W = $clog2(WORD_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BYTES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] idx_q;

  // Byte at position idx, counted from the most significant end.
  function automatic logic [BYTE_W-1:0] msb_byte(input logic [WORD_BYTES*BYTE_W-1:0] w,
                                                 input logic [CNT_W-1:0] idx);
    msb_byte = w[(WORD_BYTES - 1 - int'(idx)) * BYTE_W +: BYTE_W];
  endfunction

  assign out_valid_o = busy_q;
  assign out_data_o  = msb_byte(word_i, idx_q);
  assign finish_o    = busy_q && out_ready_i && !abort_i && (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && out_ready_i) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !abort_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: rtl/word_cmd_server.sv
module word_cmd_server
  import wsrv_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conn_start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       done,
  output logic       err
);

  localparam int WORD_W = WORD_BYTES * BYTE_W;

  wsrv_state_t state_q;
  logic [1:0]  pos_q;
  logic        kind_q;
  logic        done_q;

  logic              accept;
  logic              kw_hit, kw_last_hit, kw_kind;
  logic              start_send, pay_push, pay_commit, tx_finish;
  logic [WORD_W-1:0] word;

  assign in_ready   = !conn_start && (state_q != ST_SEND);
  assign accept     = in_valid && in_ready;
  assign start_send = accept && (state_q == ST_CMD) && kw_hit && kw_last_hit && !kw_kind;
  assign pay_push   = accept && (state_q == ST_PAY);

  wsrv_kw_match u_match (
    .byte_i (in_data),
    .pos_i  (pos_q),
    .kind_i (kind_q),
    .hit_o  (kw_hit),
    .last_o (kw_last_hit),
    .kind_o (kw_kind)
  );

  wsrv_word_store #(.WORD_BYTES(WORD_BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (conn_start),
    .push_i   (pay_push),
    .byte_i   (in_data),
    .word_o   (word),
    .commit_o (pay_commit)
  );

  wsrv_tx_stream #(.WORD_BYTES(WORD_BYTES)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_send),
    .abort_i     (conn_start),
    .word_i      (word),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .finish_o    (tx_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      pos_q   <= 2'd0;
      kind_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= !conn_start && (pay_commit || tx_finish);
      if (conn_start) begin
        state_q <= ST_CMD;
        pos_q   <= 2'd0;
        kind_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_CMD: if (accept) begin
            if (!kw_hit) begin
              state_q <= ST_ERR;
            end else if (kw_last_hit) begin
              state_q <= kw_kind ? ST_PAY : ST_SEND;
            end else begin
              pos_q  <= pos_q + 2'd1;
              kind_q <= kw_kind;
            end
          end
          ST_PAY:  if (pay_commit) state_q <= ST_FIN;
          ST_SEND: if (tx_finish)  state_q <= ST_FIN;
          default: state_q <= state_q;
        endcase
      end
    end
  end

  assign done = done_q;
  assign err  = (state_q == ST_ERR);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !conn_start) |=> err);
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conn_start |=> !err);
  // R3
  no_in_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R8
  fin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |-> !out_valid);

endmodule

// File: tb/tb_word_cmd_server.sv
`timescale 1ns/1ps
module tb_word_cmd_server;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conn_start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       done;
  logic       err;

  always #10 clk = ~clk;

  word_cmd_server dut (
    .clk(clk), .rst_n(rst_n), .conn_start(conn_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .err(err)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] model_val = 32'h0;
  int          done_cnt = 0;
  int          cyc = 0;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = 8'h00;
  logic        prev_done = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: drives out_ready, then compares handshaken bytes with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_stall) begin
        chk(out_valid && out_data == prev_data, "R3 hold while stalled", {24'h0, out_data}, {24'h0, prev_data});
      end
      if (done) done_cnt++;
      if (done && prev_done) chk(1'b0, "R9 done longer than one cycle", 32'd1, 32'd0);
      if (done && err) chk(1'b0, "R9 done with err", 32'd1, 32'd0);
      prev_done = done;
      out_ready = (cyc % 4) != 1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected output byte", {24'h0, out_data}, 32'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R2 response byte", {24'h0, out_data}, {24'h0, e});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic conn();
    conn_start = 1'b1;
    in_valid   = 1'b1;
    in_data    = 8'h47;
    #1;
    chk(in_ready == 1'b0, "R10 in_ready during conn_start", {31'h0, in_ready}, 32'h0);
    @(negedge clk);
    conn_start = 1'b0;
    in_valid   = 1'b0;
    chk(err == 1'b0, "R7 err cleared by conn_start", {31'h0, err}, 32'h0);
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 32'h0);
  endtask

  task automatic do_get(input string tag);
    int d0 = done_cnt;
    put(8'h47);
    put(8'h45);
    for (int i = 3; i >= 0; i--) exp_q.push_back(model_val[i*8 +: 8]);
    put(8'h54);
    drain({tag, " all bytes returned"});
    chk(done_cnt == d0 + 1, {tag, " R9 one done per read"}, done_cnt, d0 + 1);
  endtask

  task automatic do_post(input logic [31:0] v, input string tag);
    int d0 = done_cnt;
    put(8'h50); put(8'h4F); put(8'h53); put(8'h54);
    for (int i = 3; i >= 0; i--) put(v[i*8 +: 8]);
    model_val = v;
    @(negedge clk);
    chk(done_cnt == d0 + 1, {tag, " R9 one done per write"}, done_cnt, d0 + 1);
    chk(err == 1'b0, {tag, " R4 no err"}, {31'h0, err}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 in_ready after reset", {31'h0, in_ready}, 32'h1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {31'h0, out_valid}, 32'h0);
    chk(err == 1'b0 && done == 1'b0, "R1 err/done after reset", {30'h0, err, done}, 32'h0);
    do_get("R1 read of reset word");

    conn();
    do_post(32'hBAADF00D, "R4 write BAADF00D");
    conn();
    do_get("R7 word persists across connections");

    // R8: extra bytes after a completed read are ignored
    put(8'h47); put(8'h45); put(8'h54); put(8'h50);
    drain("R8 no output after completion");
    chk(err == 1'b0, "R8 no err on trailing bytes", {31'h0, err}, 32'h0);

    // R5: abandoned payload keeps the old word
    conn();
    put(8'h50); put(8'h4F); put(8'h53); put(8'h54); put(8'h11); put(8'h22);
    conn();
    do_get("R5 partial payload discarded");

    // R6: malformed read keyword, then a full write that must be ignored
    conn();
    put(8'h47); put(8'h58);
    chk(err == 1'b1, "R6 err on mismatch", {31'h0, err}, 32'h1);
    put(8'h50); put(8'h4F); put(8'h53); put(8'h54);
    put(8'h01); put(8'h02); put(8'h03); put(8'h04);
    drain("R6 no output while in error");
    chk(err == 1'b1, "R6 err stays high", {31'h0, err}, 32'h1);
    conn();
    do_get("R6 word unchanged by ignored write");

    // R6: bad first byte
    conn();
    put(8'h41);
    chk(err == 1'b1, "R6 err on bad first byte", {31'h0, err}, 32'h1);
    // R6: write keyword broken at second byte
    conn();
    put(8'h50); put(8'h51);
    chk(err == 1'b1, "R6 err on broken write keyword", {31'h0, err}, 32'h1);

    conn();
    do_post(32'h01020304, "R4 write 01020304");
    conn();
    do_get("R2 read 01020304");
    conn();
    do_post(32'hFF00A55A, "R4 write FF00A55A");
    conn();
    do_get("R2 read FF00A55A");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule